// File: doc/BRIEF.md
# PCI Data Parity Error Reporter

This block watches data parity on one side of a two-port PCI bridge. On every data phase the bridge takes part in, whether it initiated a read or is the target of a write, it takes the address/data lines and the byte enables, computes even parity over them and compares the result with the parity bit. That bit arrives one clock later than the data it covers. A mismatch is reported in three ways. The active-low parity error pin is pulled low at the protocol's fixed distance from the data phase, if reporting is enabled. Two sticky status flags are raised. The data is handed onward with its original, untouched parity bit and a bad-parity mark.

The bridge never repairs or absorbs a data parity error. Bad parity is carried through to the other side exactly as it was received. The transaction always ends normally: no abort and no retry is raised on account of the error. Responsibility for recovery rests with the initiator that finally consumes the data. Software clears the status flags by writing ones to them.

Top module: `pci_dperr_reporter`

## Requirements
- R1: One clock after a data phase is sampled, `fwd_bad_o` is 1 exactly when `par_i`, sampled at that next edge, differs from the XOR of all `ad_i` and `cbe_n_i` bits of the data phase (even parity).
- R2: A flagged error with `pere_i` = 1 at the following edge drives `perr_n_o` low and `perr_oe_o` high for one clock. This takes effect at the second rising edge after the edge that sampled the data phase.
- R3: With `pere_i` = 0 at that edge, `perr_n_o` stays 1 and `perr_oe_o` stays 0.
- R4: Errors on consecutive data phases keep `perr_n_o` low for consecutive clocks. After the last low clock, the pin is driven high (`perr_oe_o` = 1, `perr_n_o` = 1) for exactly one clock, and then released (`perr_oe_o` = 0).
- R5: Status bit 0 (`stat_o[0]`, detected parity error) is set at the edge where PERR# would be driven for every flagged error, whatever the value of `pere_i`.
- R6: Status bit 1 (`stat_o[1]`, parity error reported) is set only for a flagged error with `pere_i` = 1.
- R7: Both status bits are sticky. A write with `stat_wr_i` = 1 clears each bit whose `stat_wdata_i` bit is 1, and leaves bits written with 0 unchanged. A new error at the same edge wins over the clear.
- R8: One clock after a data phase, `fwd_vld_o` is 1 for one clock. `fwd_ad_o` and `fwd_cbe_n_o` equal the data phase values, and `fwd_par_o` equals the received `par_i` unchanged, even when it is wrong. A correct parity bit is never regenerated.
- R9: After a synchronous reset (`rst_n_i` = 0), `perr_n_o` = 1, `perr_oe_o` = 0, `fwd_vld_o` = 0 and `stat_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| dphase_vld_i | input | 1 | A data phase completes at this edge |
| ad_i | input | DATA_W | Address/data lines of the data phase |
| cbe_n_i | input | BE_W | Byte enables (active low) of the data phase |
| par_i | input | 1 | Parity bit, valid one clock after its data phase |
| pere_i | input | 1 | Parity error response enable for this interface |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 2 | Write-one-to-clear mask for the status bits |
| perr_n_o | output | 1 | PERR# value, active low |
| perr_oe_o | output | 1 | Output enable for PERR# |
| fwd_vld_o | output | 1 | Forwarded data phase valid |
| fwd_ad_o | output | DATA_W | Forwarded data |
| fwd_cbe_n_o | output | BE_W | Forwarded byte enables |
| fwd_par_o | output | 1 | Forwarded original parity bit |
| fwd_bad_o | output | 1 | Forwarded data carries bad parity |
| stat_o | output | 2 | Sticky status: bit 0 detected, bit 1 reported |

## Verification
Some behaviour is checked by assertions on every cycle. These cover: the link between a flagged error and a low PERR# one clock later; the absence of any low PERR# without an enabled error; the one-clock high drive before release; the stickiness of both flags; the rule that the reported flag only rises with the enable set; and the forwarding of the received parity bit unaltered. Other behaviour is shown only by the bench's directed scenarios. These cover: the exact absolute latency from the data phase; correct parity computed over chosen data and byte-enable patterns; back-to-back error trains; the per-bit clear mask; and the priority of a new error over a clear in the same edge.

// File: rtl/pci_dperr_pkg.sv
package pci_dperr_pkg;
   localparam int ST_W   = 2;
   localparam int ST_DET = 0;
   localparam int ST_RPT = 1;
endpackage

// File: rtl/pci_dperr_parity.sv
module pci_dperr_parity #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4
) (
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   cbe_n_i,
   output logic              par_o
);
   localparam int LANE_W = DATA_W / BE_W;

   logic [BE_W-1:0] lane_par;

   generate
      for (genvar g = 0; g < BE_W; g++) begin : g_lane
         assign lane_par[g] = ^{ad_i[g*LANE_W +: LANE_W], cbe_n_i[g]};
      end
   endgenerate

   assign par_o = ^lane_par;
endmodule

// File: rtl/pci_dperr_capture.sv
module pci_dperr_capture #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              dphase_vld_i,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   cbe_n_i,
   input  logic              par_i,
   output logic              fwd_vld_o,
   output logic [DATA_W-1:0] fwd_ad_o,
   output logic [BE_W-1:0]   fwd_cbe_n_o,
   output logic              fwd_par_o,
   output logic              fwd_bad_o
);
   logic              calc_par;
   logic              s1_vld;
   logic              s1_par;
   logic [DATA_W-1:0] s1_ad;
   logic [BE_W-1:0]   s1_cbe;

   pci_dperr_parity #(.DATA_W(DATA_W), .BE_W(BE_W)) u_par (
      .ad_i    (ad_i),
      .cbe_n_i (cbe_n_i),
      .par_o   (calc_par)
   );

   // stage 1: data phase, parity precomputed from lines
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         s1_vld <= 1'b0;
         s1_par <= 1'b0;
         s1_ad  <= '0;
         s1_cbe <= '0;
      end else begin
         s1_vld <= dphase_vld_i;
         s1_par <= calc_par;
         s1_ad  <= ad_i;
         s1_cbe <= cbe_n_i;
      end
   end

   // stage 2: parity bit arrives, compare and forward unchanged
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         fwd_vld_o   <= 1'b0;
         fwd_ad_o    <= '0;
         fwd_cbe_n_o <= '0;
         fwd_par_o   <= 1'b0;
         fwd_bad_o   <= 1'b0;
      end else begin
         fwd_vld_o   <= s1_vld;
         fwd_ad_o    <= s1_ad;
         fwd_cbe_n_o <= s1_cbe;
         fwd_par_o   <= par_i;
         fwd_bad_o   <= s1_vld & (s1_par ^ par_i);
      end
   end
endmodule

// File: rtl/pci_dperr_drive.sv
module pci_dperr_drive (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic err_i,
   input  logic pere_i,
   output logic perr_n_o,
   output logic perr_oe_o
);
   logic low_q;
   logic tail_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         low_q  <= 1'b0;
         tail_q <= 1'b0;
      end else begin
         low_q  <= err_i & pere_i;
         tail_q <= low_q;
      end
   end

   assign perr_n_o  = ~low_q;
   assign perr_oe_o = low_q | tail_q;
endmodule

// File: rtl/pci_dperr_status.sv
module pci_dperr_status #(
   parameter int NUM = 2
) (
   input  logic           clk_i,
   input  logic           rst_n_i,
   input  logic [NUM-1:0] set_i,
   input  logic           wr_i,
   input  logic [NUM-1:0] wdata_i,
   output logic [NUM-1:0] stat_o
);
   generate
      for (genvar g = 0; g < NUM; g++) begin : g_bit
         always_ff @(posedge clk_i) begin
            if (!rst_n_i)
               stat_o[g] <= 1'b0;
            else if (set_i[g])
               stat_o[g] <= 1'b1;
            else if (wr_i && wdata_i[g])
               stat_o[g] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/pci_dperr_reporter.sv
module pci_dperr_reporter
   import pci_dperr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BE_W   = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              dphase_vld_i,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   cbe_n_i,
   input  logic              par_i,
   input  logic              pere_i,
   input  logic              stat_wr_i,
   input  logic [ST_W-1:0]   stat_wdata_i,
   output logic              perr_n_o,
   output logic              perr_oe_o,
   output logic              fwd_vld_o,
   output logic [DATA_W-1:0] fwd_ad_o,
   output logic [BE_W-1:0]   fwd_cbe_n_o,
   output logic              fwd_par_o,
   output logic              fwd_bad_o,
   output logic [ST_W-1:0]   stat_o
);
   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of 8");
      end
      if (BE_W * 8 != DATA_W) begin : g_bad_be
         $error("BE_W must equal DATA_W/8");
      end
   endgenerate

   logic            err_evt;
   logic [ST_W-1:0] st_set;

   pci_dperr_capture #(.DATA_W(DATA_W), .BE_W(BE_W)) u_cap (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .dphase_vld_i (dphase_vld_i),
      .ad_i         (ad_i),
      .cbe_n_i      (cbe_n_i),
      .par_i        (par_i),
      .fwd_vld_o    (fwd_vld_o),
      .fwd_ad_o     (fwd_ad_o),
      .fwd_cbe_n_o  (fwd_cbe_n_o),
      .fwd_par_o    (fwd_par_o),
      .fwd_bad_o    (fwd_bad_o)
   );

   assign err_evt = fwd_vld_o & fwd_bad_o;

   pci_dperr_drive u_drv (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .err_i     (err_evt),
      .pere_i    (pere_i),
      .perr_n_o  (perr_n_o),
      .perr_oe_o (perr_oe_o)
   );

   always_comb begin
      st_set         = '0;
      st_set[ST_DET] = err_evt;
      st_set[ST_RPT] = err_evt & pere_i;
   end

   pci_dperr_status #(.NUM(ST_W)) u_st (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .set_i   (st_set),
      .wr_i    (stat_wr_i),
      .wdata_i (stat_wdata_i),
      .stat_o  (stat_o)
   );
endmodule

// File: rtl/pci_dperr_reporter_chk.sv
module pci_dperr_reporter_chk #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic              par_i,
   input logic              pere_i,
   input logic              stat_wr_i,
   input logic [1:0]        stat_wdata_i,
   input logic              perr_n_o,
   input logic              perr_oe_o,
   input logic              fwd_vld_o,
   input logic [DATA_W-1:0] fwd_ad_o,
   input logic [BE_W-1:0]   fwd_cbe_n_o,
   input logic              fwd_par_o,
   input logic              fwd_bad_o,
   input logic [1:0]        stat_o
);
   assert_bad_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      fwd_vld_o |-> (fwd_bad_o == (fwd_par_o != ^{fwd_ad_o, fwd_cbe_n_o})));

   assert_perr_low_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (fwd_vld_o && fwd_bad_o && pere_i) |=> (!perr_n_o && perr_oe_o));

   assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(fwd_vld_o && fwd_bad_o && pere_i) |=> perr_n_o);

   assert_tail_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !perr_n_o |=> perr_oe_o);

   assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (perr_n_o && $past(perr_n_o)) |-> !perr_oe_o);

   assert_det_set_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (fwd_vld_o && fwd_bad_o) |=> stat_o[0]);

   assert_rpt_only_en_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(stat_o[1]) |-> $past(fwd_vld_o && fwd_bad_o && pere_i));

   assert_sticky_det_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (stat_o[0] && !(stat_wr_i && stat_wdata_i[0])) |=> stat_o[0]);

   assert_sticky_rpt_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (stat_o[1] && !(stat_wr_i && stat_wdata_i[1])) |=> stat_o[1]);

   assert_fwd_par_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      fwd_vld_o |-> (fwd_par_o == $past(par_i)));
endmodule

bind pci_dperr_reporter pci_dperr_reporter_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
   .clk_i        (clk_i),
   .rst_n_i      (rst_n_i),
   .par_i        (par_i),
   .pere_i       (pere_i),
   .stat_wr_i    (stat_wr_i),
   .stat_wdata_i (stat_wdata_i),
   .perr_n_o     (perr_n_o),
   .perr_oe_o    (perr_oe_o),
   .fwd_vld_o    (fwd_vld_o),
   .fwd_ad_o     (fwd_ad_o),
   .fwd_cbe_n_o  (fwd_cbe_n_o),
   .fwd_par_o    (fwd_par_o),
   .fwd_bad_o    (fwd_bad_o),
   .stat_o       (stat_o)
);

// File: tb/pci_dperr_reporter_bench.sv
module pci_dperr_reporter_bench;
   localparam int DW = 32;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          dphase_vld;
   logic [DW-1:0] ad;
   logic [BW-1:0] cbe_n;
   logic          par;
   logic          pere;
   logic          stat_wr;
   logic [1:0]    stat_wdata;
   logic          perr_n, perr_oe, fwd_vld, fwd_par, fwd_bad;
   logic [DW-1:0] fwd_ad;
   logic [BW-1:0] fwd_cbe_n;
   logic [1:0]    stat;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   pci_dperr_reporter #(.DATA_W(DW), .BE_W(BW)) u_pci_dperr_reporter (
      .clk_i(clk), .rst_n_i(rst_n), .dphase_vld_i(dphase_vld), .ad_i(ad),
      .cbe_n_i(cbe_n), .par_i(par), .pere_i(pere), .stat_wr_i(stat_wr),
      .stat_wdata_i(stat_wdata), .perr_n_o(perr_n), .perr_oe_o(perr_oe),
      .fwd_vld_o(fwd_vld), .fwd_ad_o(fwd_ad), .fwd_cbe_n_o(fwd_cbe_n),
      .fwd_par_o(fwd_par), .fwd_bad_o(fwd_bad), .stat_o(stat)
   );

   function automatic logic even_par(input logic [DW-1:0] d, input logic [BW-1:0] b);
      return ^{d, b};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_stat(input logic [1:0] v);
      stat_wr = 1'b1; stat_wdata = v;
      tick();
      stat_wr = 1'b0; stat_wdata = 2'b00;
   endtask

   task automatic t_reset();
      chk("R9", "perr_n", perr_n, 1);
      chk("R9", "perr_oe", perr_oe, 0);
      chk("R9", "fwd_vld", fwd_vld, 0);
      chk("R9", "stat", stat, 0);
   endtask

   task automatic t_single(input logic en, input logic [DW-1:0] d, input logic [BW-1:0] b,
                           input logic corrupt);
      logic p;
      p = even_par(d, b) ^ corrupt;
      pere = en;
      dphase_vld = 1'b1; ad = d; cbe_n = b; par = 1'b0;
      tick();                                    // data phase edge
      dphase_vld = 1'b0; ad = '0; cbe_n = '0; par = p;
      tick();                                    // parity edge
      chk("R1", "fwd_bad", fwd_bad, corrupt);
      chk("R8", "fwd_vld", fwd_vld, 1);
      chk("R8", "fwd_ad", fwd_ad, d);
      chk("R8", "fwd_cbe_n", fwd_cbe_n, b);
      chk("R8", "fwd_par unchanged", fwd_par, p);
      chk("R2", "perr_n not early", perr_n, 1);
      par = 1'b0;
      tick();                                    // second edge after data
      chk(en ? "R2" : "R3", "perr_n", perr_n, !(corrupt && en));
      chk(en ? "R2" : "R3", "perr_oe", perr_oe, corrupt && en);
      chk("R5", "stat det", stat[0], corrupt);
      chk("R6", "stat rpt", stat[1], corrupt && en);
      chk("R8", "fwd_vld one clock", fwd_vld, 0);
      tick();
      chk("R4", "perr_n high tail", perr_n, 1);
      chk("R4", "perr_oe tail", perr_oe, corrupt && en);
      tick();
      chk("R4", "perr_oe released", perr_oe, 0);
      wr_stat(2'b11);
      chk("R7", "stat cleared", stat, 0);
   endtask

   task automatic t_back_to_back();
      logic [DW-1:0] d0, d1, d2;
      d0 = 32'h1234_5678; d1 = 32'hFFFF_0000; d2 = 32'h0F0F_00A5;
      pere = 1'b1;
      dphase_vld = 1'b1; ad = d0; cbe_n = 4'h0; par = 1'b0;
      tick();
      ad = d1; cbe_n = 4'h5; par = ~even_par(d0, 4'h0);
      tick();
      chk("R1", "b2b fwd_bad 0", fwd_bad, 1);
      ad = d2; cbe_n = 4'hE; par = ~even_par(d1, 4'h5);
      tick();
      chk("R4", "b2b perr_n first", perr_n, 0);
      chk("R1", "b2b fwd_bad 1", fwd_bad, 1);
      dphase_vld = 1'b0; ad = '0; cbe_n = '0; par = even_par(d2, 4'hE);
      tick();
      chk("R4", "b2b perr_n second", perr_n, 0);
      chk("R4", "b2b perr_oe second", perr_oe, 1);
      chk("R1", "b2b fwd_bad 2 good", fwd_bad, 0);
      par = 1'b0;
      tick();
      chk("R4", "b2b tail perr_n", perr_n, 1);
      chk("R4", "b2b tail perr_oe", perr_oe, 1);
      tick();
      chk("R4", "b2b released", perr_oe, 0);
      wr_stat(2'b11);
   endtask

   task automatic t_w1c();
      logic [DW-1:0] d;
      d = 32'hA5A5_3C3C;
      pere = 1'b1;
      dphase_vld = 1'b1; ad = d; cbe_n = 4'h3; par = 1'b0;
      tick();
      dphase_vld = 1'b0; par = ~even_par(d, 4'h3);
      tick();
      par = 1'b0;
      tick();
      chk("R7", "both set", stat, 2'b11);
      wr_stat(2'b00);
      chk("R7", "write 0 no effect", stat, 2'b11);
      wr_stat(2'b01);
      chk("R7", "clear det only", stat, 2'b10);
      wr_stat(2'b10);
      chk("R7", "clear rpt", stat, 2'b00);
      tick();
      chk("R7", "stays clear", stat, 2'b00);
      // new error at the same edge as a clear: set wins
      dphase_vld = 1'b1; ad = d; cbe_n = 4'h3; par = 1'b0;
      tick();
      dphase_vld = 1'b0; par = ~even_par(d, 4'h3);
      tick();
      par = 1'b0; stat_wr = 1'b1; stat_wdata = 2'b11;
      tick();
      stat_wr = 1'b0; stat_wdata = 2'b00;
      chk("R7", "set wins over clear", stat, 2'b11);
      tick();
      wr_stat(2'b11);
   endtask

   initial begin
      #(20 * 20000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; dphase_vld = 1'b0; ad = '0; cbe_n = '0; par = 1'b0;
      pere = 1'b0; stat_wr = 1'b0; stat_wdata = 2'b00;
      repeat (3) tick();
      rst_n = 1'b1;
      t_reset();
      t_single(1'b1, 32'hDEAD_BEEF, 4'h0, 1'b1);
      t_single(1'b0, 32'h0000_0001, 4'hF, 1'b1);
      t_single(1'b1, 32'h8001_0203, 4'h9, 1'b0);
      t_single(1'b1, 32'h0000_0000, 4'h1, 1'b1);
      t_back_to_back();
      t_w1c();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule